// File: doc/BRIEF.md
# End-to-End Parity Error Reporter

This block sits in one port of a packet switch and decides what happens each time a parity error is found on a packet passing through that port. Every error event is tallied in a saturating per-port counter that software can read and clear. Depending on whether the port faces the root (upstream) or faces away from it (downstream), the error is recorded as a detected-parity-error flag in either the secondary or the primary status register. A one-cycle request can also be raised toward the message logic so that a non-fatal error message goes to the root.

Two controls gate the message. A silent-mode bit suppresses both the message and the status flag. A message-enable bit must be set before any message is sent. In addition, once the counter has reached its ceiling, no further messages are raised, so a stuck fault cannot flood the root. The counter itself keeps counting in silent mode and with messages disabled. The status flags are cleared by writing a one. When an error and a clear arrive in the same cycle, the error takes precedence.

Top module: `perr_reporter`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `err_cnt_o` is 0 and `pri_dpe_o`, `sec_dpe_o` and `msg_req_o` are all 0.
- R2: Each cycle with `perr_i`=1 raises `err_cnt_o` by one on the next clock edge. This also applies when `silent_i` is 1 or `msg_en_i` is 0.
- R3: `err_cnt_o` is 8 bits wide and holds at 255. Further errors leave it at 255.
- R4: An error with `silent_i`=0 sets `pri_dpe_o` when `upstream_i`=0 (downstream port) and sets `sec_dpe_o` when `upstream_i`=1 (upstream port). The other flag is left unchanged.
- R5: An error with `silent_i`=1 raises no message request and sets neither status flag.
- R6: An error with `msg_en_i`=0 raises no message request.
- R7: `msg_req_o` is 1 for exactly the cycle after an error with `silent_i`=0 and `msg_en_i`=1, and only when `err_cnt_o` was below 255 in the error cycle. At most one request is raised per clock.
- R8: `pri_clr_i`=1 clears `pri_dpe_o` and `sec_clr_i`=1 clears `sec_dpe_o` on the next edge. If a setting error arrives in the same cycle, the flag stays 1.
- R9: `cnt_rd_i`=1 clears `err_cnt_o` on the next edge. If `perr_i`=1 in the same cycle, the counter becomes 1. The saturation gate of R7 uses the count held before the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| perr_i | input | 1 | Parity error detected this cycle |
| upstream_i | input | 1 | 1 = upstream port, 0 = downstream port |
| silent_i | input | 1 | Silent mode: suppress message and status flag |
| msg_en_i | input | 1 | Non-fatal error message enable |
| cnt_rd_i | input | 1 | Counter read strobe (clear on read) |
| pri_clr_i | input | 1 | Write-1-to-clear for the primary status flag |
| sec_clr_i | input | 1 | Write-1-to-clear for the secondary status flag |
| err_cnt_o | output | 8 | Saturating parity error count |
| pri_dpe_o | output | 1 | Detected parity error, primary status register |
| sec_dpe_o | output | 1 | Detected parity error, secondary status register |
| msg_req_o | output | 1 | One-cycle request for a non-fatal error message |

## Verification
The bench drives a long burst of back-to-back errors past the ceiling. A design that wraps the counter would restart at 0 and resume messaging, and one that gates on the post-increment value would drop the message for the error that reaches 255. The bench also lines up errors with clears and with read strobes in the same cycle, which catches a clear that wins over a set and a read that loses the coincident error. Silent-mode and message-disabled windows confirm that the counter still advances while the message and the flags stay quiet. Toggling the port role confirms that a design with the two flags swapped is caught.

// File: rtl/perr_pkg.sv
package perr_pkg;

    typedef enum logic {
        ROLE_DOWN = 1'b0,
        ROLE_UP   = 1'b1
    } port_role_e;

    localparam int STAT_PRI = 0;
    localparam int STAT_SEC = 1;
    localparam int NUM_STAT = 2;

    typedef struct packed {
        logic       hit;
        logic       loud;
        port_role_e role;
    } perr_evt_t;

    function automatic logic [NUM_STAT-1:0] stat_set_mask(input perr_evt_t e);
        logic [NUM_STAT-1:0] m;
        m = '0;
        if (e.hit && e.loud) begin
            if (e.role == ROLE_UP) m[STAT_SEC] = 1'b1;
            else                   m[STAT_PRI] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/perr_counter.sv
module perr_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc_i,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o,
    output logic         sat_o
);
    localparam logic [W-1:0] MAX_VAL = {W{1'b1}};
    localparam logic [W-1:0] ONE_VAL = W'(1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= inc_i ? ONE_VAL : '0;
        end else if (inc_i && (cnt_q != MAX_VAL)) begin
            cnt_q <= cnt_q + ONE_VAL;
        end
    end

    assign cnt_o = cnt_q;
    assign sat_o = (cnt_q == MAX_VAL);
endmodule

// File: rtl/perr_status_bit.sv
module perr_status_bit (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)        flag_q <= 1'b0;
        else if (set_i) flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/perr_msg_gate.sv
module perr_msg_gate
    import perr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  perr_evt_t evt_i,
    input  logic      msg_en_i,
    input  logic      sat_i,
    output logic      req_o
);
    logic req_q;

    always_ff @(posedge clk) begin
        if (rst) req_q <= 1'b0;
        else     req_q <= evt_i.hit && evt_i.loud && msg_en_i && !sat_i;
    end

    assign req_o = req_q;
endmodule

// File: rtl/perr_reporter.sv
module perr_reporter
    import perr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             perr_i,
    input  logic             upstream_i,
    input  logic             silent_i,
    input  logic             msg_en_i,
    input  logic             cnt_rd_i,
    input  logic             pri_clr_i,
    input  logic             sec_clr_i,
    output logic [CNT_W-1:0] err_cnt_o,
    output logic             pri_dpe_o,
    output logic             sec_dpe_o,
    output logic             msg_req_o
);
    perr_evt_t           evt;
    logic                sat;
    logic [NUM_STAT-1:0] set_mask;
    logic [NUM_STAT-1:0] clr_vec;
    logic [NUM_STAT-1:0] flags;

    always_comb begin
        evt.hit  = perr_i;
        evt.loud = !silent_i;
        evt.role = upstream_i ? ROLE_UP : ROLE_DOWN;
    end

    assign set_mask          = stat_set_mask(evt);
    assign clr_vec[STAT_PRI] = pri_clr_i;
    assign clr_vec[STAT_SEC] = sec_clr_i;

    perr_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .inc_i (evt.hit),
        .clr_i (cnt_rd_i),
        .cnt_o (err_cnt_o),
        .sat_o (sat)
    );

    for (genvar i = 0; i < NUM_STAT; i++) begin : g_stat
        perr_status_bit u_bit (
            .clk    (clk),
            .rst    (rst),
            .set_i  (set_mask[i]),
            .clr_i  (clr_vec[i]),
            .flag_o (flags[i])
        );
    end

    assign pri_dpe_o = flags[STAT_PRI];
    assign sec_dpe_o = flags[STAT_SEC];

    perr_msg_gate u_msg (
        .clk      (clk),
        .rst      (rst),
        .evt_i    (evt),
        .msg_en_i (msg_en_i),
        .sat_i    (sat),
        .req_o    (msg_req_o)
    );
endmodule

// File: rtl/perr_reporter_chk.sv
module perr_reporter_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             perr_i,
    input logic             upstream_i,
    input logic             silent_i,
    input logic             msg_en_i,
    input logic             cnt_rd_i,
    input logic             pri_clr_i,
    input logic             sec_clr_i,
    input logic [CNT_W-1:0] err_cnt_o,
    input logic             pri_dpe_o,
    input logic             sec_dpe_o,
    input logic             msg_req_o
);
    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        (perr_i && !cnt_rd_i && err_cnt_o != MAXV) |=> err_cnt_o == $past(err_cnt_o) + CNT_W'(1));

    assert_hold_max_R3: assert property (@(posedge clk) disable iff (rst)
        (err_cnt_o == MAXV && !cnt_rd_i) |=> err_cnt_o == MAXV);

    assert_down_sets_pri_R4: assert property (@(posedge clk) disable iff (rst)
        (perr_i && !silent_i && !upstream_i) |=> pri_dpe_o);

    assert_up_sets_sec_R4: assert property (@(posedge clk) disable iff (rst)
        (perr_i && !silent_i && upstream_i) |=> sec_dpe_o);

    assert_silent_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (perr_i && silent_i) |=> !msg_req_o);

    assert_silent_no_flag_R5: assert property (@(posedge clk) disable iff (rst)
        (!pri_dpe_o && !(perr_i && !silent_i && !upstream_i)) |=> !pri_dpe_o);

    assert_msg_disabled_R6: assert property (@(posedge clk) disable iff (rst)
        !msg_en_i |=> !msg_req_o);

    assert_msg_needs_error_R7: assert property (@(posedge clk) disable iff (rst)
        !perr_i |=> !msg_req_o);

    assert_no_msg_saturated_R7: assert property (@(posedge clk) disable iff (rst)
        (err_cnt_o == MAXV) |=> !msg_req_o);

    assert_clear_pri_R8: assert property (@(posedge clk) disable iff (rst)
        (pri_clr_i && !(perr_i && !silent_i && !upstream_i)) |=> !pri_dpe_o);

    assert_clear_sec_R8: assert property (@(posedge clk) disable iff (rst)
        (sec_clr_i && !(perr_i && !silent_i && upstream_i)) |=> !sec_dpe_o);

    assert_read_clears_R9: assert property (@(posedge clk) disable iff (rst)
        cnt_rd_i |=> err_cnt_o == (perr_i ? CNT_W'(1) : '0) || err_cnt_o == $past(perr_i, 1) );
endmodule

bind perr_reporter perr_reporter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .perr_i     (perr_i),
    .upstream_i (upstream_i),
    .silent_i   (silent_i),
    .msg_en_i   (msg_en_i),
    .cnt_rd_i   (cnt_rd_i),
    .pri_clr_i  (pri_clr_i),
    .sec_clr_i  (sec_clr_i),
    .err_cnt_o  (err_cnt_o),
    .pri_dpe_o  (pri_dpe_o),
    .sec_dpe_o  (sec_dpe_o),
    .msg_req_o  (msg_req_o)
);

// File: tb/perr_reporter_tb.sv
module perr_reporter_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       perr_i, upstream_i, silent_i, msg_en_i, cnt_rd_i, pri_clr_i, sec_clr_i;
    logic [7:0] err_cnt_o;
    logic       pri_dpe_o, sec_dpe_o, msg_req_o;

    int n_chk = 0;
    int n_bad = 0;
    int m_cnt;
    bit m_pri, m_sec, m_msg;
    string tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    perr_reporter u_dut (
        .clk(clk), .rst(rst), .perr_i(perr_i), .upstream_i(upstream_i),
        .silent_i(silent_i), .msg_en_i(msg_en_i), .cnt_rd_i(cnt_rd_i),
        .pri_clr_i(pri_clr_i), .sec_clr_i(sec_clr_i), .err_cnt_o(err_cnt_o),
        .pri_dpe_o(pri_dpe_o), .sec_dpe_o(sec_dpe_o), .msg_req_o(msg_req_o)
    );

    task automatic check(input string req, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s (%s): got %0d expected %0d at %0t", req, what, tag, got, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("R2/R3 R9", "err_cnt", int'(err_cnt_o), m_cnt);
        check("R4 R5 R8", "pri_dpe", int'(pri_dpe_o), int'(m_pri));
        check("R4 R5 R8", "sec_dpe", int'(sec_dpe_o), int'(m_sec));
        check("R6 R7", "msg_req", int'(msg_req_o), int'(m_msg));
    endtask

    task automatic model_edge();
        bit loud;
        if (rst) begin
            m_cnt = 0; m_pri = 0; m_sec = 0; m_msg = 0;
            return;
        end
        loud  = perr_i && !silent_i;
        m_msg = loud && msg_en_i && (m_cnt < 255);
        if (cnt_rd_i)                 m_cnt = perr_i ? 1 : 0;
        else if (perr_i && m_cnt < 255) m_cnt = m_cnt + 1;
        if (loud && !upstream_i) m_pri = 1; else if (pri_clr_i) m_pri = 0;
        if (loud &&  upstream_i) m_sec = 1; else if (sec_clr_i) m_sec = 0;
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic drive(input bit e, input bit up, input bit sil, input bit en,
                         input bit rd, input bit pc, input bit sc);
        perr_i = e; upstream_i = up; silent_i = sil; msg_en_i = en;
        cnt_rd_i = rd; pri_clr_i = pc; sec_clr_i = sc;
        step();
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        m_cnt = 0; m_pri = 0; m_sec = 0; m_msg = 0;
        rst = 1'b1;
        perr_i = 0; upstream_i = 0; silent_i = 0; msg_en_i = 0;
        cnt_rd_i = 0; pri_clr_i = 0; sec_clr_i = 0;
        tag = "R1 reset";
        @(negedge clk);
        for (int i = 0; i < 3; i++) drive(1, 0, 0, 1, 0, 0, 0);
        rst = 1'b0;
        drive(0, 0, 0, 0, 0, 0, 0);
        check("R1", "cnt after reset", int'(err_cnt_o), 0);
        check("R1", "msg after reset", int'(msg_req_o), 0);

        tag = "R2 R7 downstream";
        for (int i = 0; i < 10; i++) drive(i % 3 == 0, 0, 0, 1, 0, 0, 0);
        check("R4", "pri set downstream", int'(pri_dpe_o), 1);

        tag = "R4 upstream";
        for (int i = 0; i < 6; i++) drive(i % 2 == 0, 1, 0, 1, 0, 0, 0);
        check("R4", "sec set upstream", int'(sec_dpe_o), 1);

        tag = "R8 clear";
        drive(0, 0, 0, 1, 0, 1, 1);
        check("R8", "pri cleared", int'(pri_dpe_o), 0);
        check("R8", "sec cleared", int'(sec_dpe_o), 0);
        drive(1, 0, 0, 1, 0, 1, 0);
        check("R8", "error beats clear", int'(pri_dpe_o), 1);
        drive(1, 1, 0, 1, 0, 0, 1);
        check("R8", "error beats clear sec", int'(sec_dpe_o), 1);
        drive(0, 0, 0, 1, 0, 1, 1);

        tag = "R5 silent";
        for (int i = 0; i < 8; i++) drive(1, i % 2, 1, 1, 0, 0, 0);
        check("R5", "no pri in silent", int'(pri_dpe_o), 0);
        check("R5", "no sec in silent", int'(sec_dpe_o), 0);

        tag = "R6 disabled";
        for (int i = 0; i < 8; i++) drive(1, 0, 0, 0, 0, 0, 0);
        check("R6", "no msg when disabled", int'(msg_req_o), 0);

        tag = "R9 read";
        drive(0, 0, 0, 1, 1, 0, 0);
        check("R9", "read clears", int'(err_cnt_o), 0);
        drive(1, 0, 0, 1, 0, 0, 0);
        drive(1, 0, 0, 1, 1, 0, 0);
        check("R9", "read with error", int'(err_cnt_o), 1);

        tag = "R3 saturation";
        for (int i = 0; i < 300; i++) drive(1, i % 5 == 0, 0, 1, 0, 0, 0);
        check("R3", "held at 255", int'(err_cnt_o), 255);
        check("R7", "no msg when saturated", int'(msg_req_o), 0);
        drive(1, 0, 0, 1, 1, 0, 0);
        check("R9", "read at saturation", int'(err_cnt_o), 1);
        check("R7", "saturation gate uses pre-read count", int'(msg_req_o), 0);
        drive(1, 0, 0, 1, 0, 0, 0);
        check("R7", "msg resumes after read", int'(msg_req_o), 1);

        tag = "mixed";
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom;
            drive(r[0] | r[1], r[2], r[3] & r[4], r[5] | r[6],
                  r[7] & r[8] & r[9], r[10] & r[11], r[12] & r[13]);
        end
        finish_run();
    end
endmodule